// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point unit and turns the per-operation status that the unit reports into sticky exception flags. The flags live in a floating-point control/status register. One bit of that register is an exception-enable bit. While the enable bit is set, each valid status vector from the unit is folded into the flags. While it is clear, the status is dropped.

Nine separate invalid-operation sub-causes all feed one summary invalid flag. Two of those sub-causes, signaling NaN and quiet NaN, also set flags of their own. Two others, infinity minus infinity and infinity divided by infinity, set an infinity flag. Overflow, underflow, divide-by-zero and inexact each map straight onto a dedicated flag.

After every enabled update, the block looks at the whole flag set. If any flag is set, it sends the core a one-cycle exception request, together with the address of the instruction before the current one. Software can overwrite the register at any time. A write that lands in the same cycle as an update is applied first, and the new status is then ORed onto the written value.

Top module: `fpu_flag_accum`

## Requirements
- R1: While reset is asserted and after it is released, the register reads zero, the exception request is low and the reported PC is zero.
- R2: A software write stores write-data bit 0 as the enable bit and write-data bits 8:1 as the flags. The new value is visible the cycle after the write. Register bits above bit 8 always read zero.
- R3: A status vector is ignored when the enable bit (register bit 0) held before that edge is clear, or when the status-valid input is low. In that case the flags do not change and no request is made.
- R4: The status vector has one bit per cause. Bits 0 to 8 are the invalid sub-causes: 0 signaling NaN, 1 quiet NaN, 2 infinity minus infinity, 3 infinity divided by infinity, 4 zero divided by zero, 5 infinity times zero, 6 invalid conversion, 7 invalid compare, 8 invalid square root. When updates are enabled, any one of them sets the invalid flag, register bit 1.
- R5: Cause bit 0 also sets the signaling-NaN flag (register bit 2), and cause bit 1 also sets the quiet-NaN flag (register bit 3).
- R6: The infinity flag (register bit 6) is set by cause bits 2 and 3 only.
- R7: Cause bit 9 (overflow) sets register bit 4. Cause bit 10 (underflow) sets bit 5. Cause bit 11 (divide by zero) sets bit 7. Cause bit 12 (inexact) sets bit 8.
- R8: Flags are sticky. Without a software write or a reset, a set flag stays set.
- R9: When a software write and an enabled update happen in the same cycle, the register becomes the written value ORed with the flags derived from the status. Whether the update is enabled depends on the enable bit held before the write.
- R10: The exception request is high for exactly the one cycle that follows an enabled update, and only if at least one of the eight flags is set after that update. This includes flags left over from earlier updates.
- R11: When a request is raised, the reported PC takes the value the previous-instruction PC input had at the update. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Status vector valid this cycle |
| st_cause | input | CAUSE_W (13) | One-hot-per-cause status from the FPU |
| prev_pc | input | PC_W (32) | Address of the previous instruction |
| sw_we | input | 1 | Software write strobe for the register |
| sw_wdata | input | REG_W (32) | Software write data |
| csr_rdata | output | REG_W (32) | Register contents |
| exc_req | output | 1 | One-cycle floating-point exception request |
| exc_pc | output | PC_W (32) | PC reported with the request |

## Verification
The bench sweeps all 8192 cause vectors, each one paired with a clearing write in the same cycle. This catches a summary flag that misses an invalid sub-cause, an infinity flag raised by the wrong sub-cause, and a write that wipes out the status of its own cycle instead of being ORed with it.

Further sequences test the following:
- Flags must survive idle cycles and later updates. A design without sticky flags would lose them.
- An update whose status is all zero must still raise a request when old flags are set. A design that looked only at the new status would stay silent.
- A write that turns the enable bit off must still let that cycle's status through, because gating uses the enable bit held before the write.
- With the enable bit clear, or with status-valid low, the status must change nothing, and the reported PC must hold its value.

// File: rtl/fpu_flag_pkg.sv
package fpu_flag_pkg;

  // Status vector bit positions
  localparam int unsigned C_SNAN  = 0;
  localparam int unsigned C_QNAN  = 1;
  localparam int unsigned C_ISI   = 2;
  localparam int unsigned C_IDI   = 3;
  localparam int unsigned C_ZDZ   = 4;
  localparam int unsigned C_IMZ   = 5;
  localparam int unsigned C_CVT   = 6;
  localparam int unsigned C_CMP   = 7;
  localparam int unsigned C_SQRT  = 8;
  localparam int unsigned N_INV   = 9;
  localparam int unsigned C_OVF   = 9;
  localparam int unsigned C_UNF   = 10;
  localparam int unsigned C_DZ    = 11;
  localparam int unsigned C_IX    = 12;
  localparam int unsigned N_CAUSE = 13;

  // Register field layout: bit 0 enable, bits 8:1 flags
  localparam int unsigned N_FLAG  = 8;
  localparam int unsigned FLD_W   = N_FLAG + 1;

  typedef struct packed {
    logic ix;    // reg bit 8
    logic dz;    // reg bit 7
    logic inf;   // reg bit 6
    logic unf;   // reg bit 5
    logic ovf;   // reg bit 4
    logic qnan;  // reg bit 3
    logic snan;  // reg bit 2
    logic inv;   // reg bit 1
  } fflags_t;

endpackage

// File: rtl/fpu_cause_fold.sv
module fpu_cause_fold
  import fpu_flag_pkg::*;
#(
  parameter int unsigned CAUSE_W = N_CAUSE
) (
  input  logic [CAUSE_W-1:0] cause,
  output fflags_t            flags
);

  logic [N_INV-1:0] inv_vec;

  // Gather the invalid sub-causes into one vector
  for (genvar g = 0; g < N_INV; g++) begin : g_inv
    assign inv_vec[g] = cause[g];
  end

  always_comb begin
    flags      = '0;
    flags.inv  = |inv_vec;
    flags.snan = cause[C_SNAN];
    flags.qnan = cause[C_QNAN];
    flags.inf  = cause[C_ISI] | cause[C_IDI];
    flags.ovf  = cause[C_OVF];
    flags.unf  = cause[C_UNF];
    flags.dz   = cause[C_DZ];
    flags.ix   = cause[C_IX];
  end

endmodule

// File: rtl/fpu_flag_reg.sv
module fpu_flag_reg
  import fpu_flag_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  fflags_t          upd_flags,
  input  logic             sw_we,
  input  logic [REG_W-1:0] sw_wdata,
  output logic             en_q,
  output fflags_t          flags_q,
  output fflags_t          flags_nxt
);

  logic    en_nxt;
  fflags_t base;

  // Next state: the write is applied first, then the status is ORed on
  always_comb begin
    if (sw_we) begin
      en_nxt = sw_wdata[0];
      base   = fflags_t'(sw_wdata[FLD_W-1:1]);
    end else begin
      en_nxt = en_q;
      base   = flags_q;
    end
    flags_nxt = upd ? (base | upd_flags) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flags_q <= '0;
    end else if (sw_we || upd) begin
      en_q    <= en_nxt;
      flags_q <= flags_nxt;
    end
  end

endmodule

// File: rtl/fpu_exc_req.sv
module fpu_exc_req
  import fpu_flag_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  fflags_t         flags_nxt,
  input  logic [PC_W-1:0] pc_i,
  output logic            req_q,
  output logic [PC_W-1:0] pc_q
);

  logic req_nxt;

  always_comb req_nxt = upd & (|flags_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (req_nxt) pc_q <= pc_i;
  end

endmodule

// File: rtl/fpu_flag_accum.sv
module fpu_flag_accum
  import fpu_flag_pkg::*;
#(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = N_CAUSE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  input  logic [CAUSE_W-1:0] st_cause,
  input  logic [PC_W-1:0]    prev_pc,
  input  logic               sw_we,
  input  logic [REG_W-1:0]   sw_wdata,
  output logic [REG_W-1:0]   csr_rdata,
  output logic               exc_req,
  output logic [PC_W-1:0]    exc_pc
);

  localparam int unsigned PAD_W = REG_W - FLD_W;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       en_q;
  logic       upd;
  fflags_t    st_flags;
  fflags_t    flags_q;
  fflags_t    flags_nxt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign upd = st_valid & en_q;

  fpu_cause_fold #(.CAUSE_W(CAUSE_W)) u_fold (
    .cause (st_cause),
    .flags (st_flags)
  );

  fpu_flag_reg #(.REG_W(REG_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd       (upd),
    .upd_flags (st_flags),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .en_q      (en_q),
    .flags_q   (flags_q),
    .flags_nxt (flags_nxt)
  );

  fpu_exc_req #(.PC_W(PC_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd       (upd),
    .flags_nxt (flags_nxt),
    .pc_i      (prev_pc),
    .req_q     (exc_req),
    .pc_q      (exc_pc)
  );

  assign csr_rdata = {{PAD_W{1'b0}}, flags_q, en_q};

endmodule

// File: rtl/fpu_flag_accum_chk.sv
module fpu_flag_accum_chk #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic [CAUSE_W-1:0] st_cause,
  input logic               sw_we,
  input logic [REG_W-1:0]   csr_rdata,
  input logic               exc_req,
  input logic [PC_W-1:0]    exc_pc
);

  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && (!st_valid || !csr_rdata[0])) |=> $stable(csr_rdata));

  p_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && csr_rdata[0] && (|st_cause[8:0])) |=> csr_rdata[1]);

  p_inf_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !csr_rdata[6] && !(st_valid && csr_rdata[0] && (|st_cause[3:2])))
      |=> !csr_rdata[6]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((csr_rdata[8:1] & $past(csr_rdata[8:1])) == $past(csr_rdata[8:1])));

  p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(st_valid && csr_rdata[0]) && (|csr_rdata[8:1])));

  p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> $stable(exc_pc));

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[REG_W-1:9] == '0);

endmodule

bind fpu_flag_accum fpu_flag_accum_chk #(
  .REG_W(REG_W), .PC_W(PC_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_cause  (st_cause),
  .sw_we     (sw_we),
  .csr_rdata (csr_rdata),
  .exc_req   (exc_req),
  .exc_pc    (exc_pc)
);

// File: tb/tb_fpu_flag_accum.sv
module tb_fpu_flag_accum;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid;
  logic [12:0] st_cause;
  logic [31:0] prev_pc;
  logic        sw_we;
  logic [31:0] sw_wdata;
  logic [31:0] csr_rdata;
  logic        exc_req;
  logic [31:0] exc_pc;

  int n_chk  = 0;
  int n_fail = 0;

  logic [8:0]  m_reg;
  logic [31:0] m_pc;
  logic        m_req;

  always #(CLK_P/2) clk = ~clk;

  fpu_flag_accum dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_cause(st_cause),
    .prev_pc(prev_pc), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .csr_rdata(csr_rdata), .exc_req(exc_req), .exc_pc(exc_pc)
  );

  // Expected flags {ix,dz,inf,unf,ovf,qnan,snan,inv}
  function automatic logic [7:0] fold(input logic [12:0] c);
    fold = {c[12], c[11], c[2] | c[3], c[10], c[9], c[1], c[0], |c[8:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle, update the model, land on the next negedge
  task automatic cyc(input logic v, input logic [12:0] c, input logic we,
                     input logic [31:0] wd, input logic [31:0] pc);
    logic       upd;
    logic [8:0] nxt;
    st_valid = v; st_cause = c; sw_we = we; sw_wdata = wd; prev_pc = pc;
    upd = v & m_reg[0];
    nxt = we ? wd[8:0] : m_reg;
    if (upd) nxt = nxt | {fold(c), 1'b0};
    m_req = upd && (|nxt[8:1]);
    if (m_req) m_pc = pc;
    m_reg = nxt;
    @(negedge clk);
    st_valid = 1'b0; st_cause = '0; sw_we = 1'b0; sw_wdata = '0;
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " reg"}, csr_rdata, {23'd0, m_reg});
    chk({tag, " req"}, {31'd0, exc_req}, {31'd0, m_req});
    chk({tag, " pc"},  exc_pc, m_pc);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    st_valid = 0; st_cause = '0; sw_we = 0; sw_wdata = '0; prev_pc = '0;
    m_reg = '0; m_pc = '0; m_req = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset reg", csr_rdata, 32'd0);
    chk("R1 reset req", {31'd0, exc_req}, 32'd0);
    chk("R1 reset pc", exc_pc, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");

    // R3: enable clear, all causes
    cyc(1, 13'h1FFF, 0, 0, 32'h1111);
    chk_all("R3 disabled");

    // R2: write all ones, upper bits must read zero
    cyc(0, 0, 1, 32'hFFFF_FFFF, 0);
    chk_all("R2 write ones");
    cyc(0, 0, 1, 32'h0000_0001, 0);
    chk_all("R2 write enable only");

    // R3: valid low with causes present
    cyc(0, 13'h1FFF, 0, 0, 32'h2222);
    chk_all("R3 valid low");

    // R4 R5 R6 R7 R9 R10 R11: sweep all cause vectors with a same-cycle clearing write
    for (int i = 0; i < 8192; i++) begin
      logic [7:0] f;
      f = fold(13'(i));
      cyc(1, 13'(i), 1, 32'h1, 32'hA5A5_0000 ^ i);
      chk("R4 invalid", {31'd0, csr_rdata[1]}, {31'd0, f[0]});
      chk("R5 nan flags", {30'd0, csr_rdata[3:2]}, {30'd0, f[2:1]});
      chk("R6 inf", {31'd0, csr_rdata[6]}, {31'd0, f[5]});
      chk("R7 ovf/unf/dz/ix", {28'd0, csr_rdata[8:7], csr_rdata[5:4]},
          {28'd0, f[7:6], f[4:3]});
      chk("R9 write or status", csr_rdata, {23'd0, f, 1'b1});
      chk("R10 req", {31'd0, exc_req}, {31'd0, f != 0});
      chk("R11 pc", exc_pc, m_pc);
    end

    // R8: sticky accumulation
    cyc(0, 0, 1, 32'h1, 0);
    cyc(1, 13'h0200, 0, 0, 32'h3000);
    chk_all("R8 ovf set");
    cyc(1, 13'h1000, 0, 0, 32'h3004);
    chk_all("R8 ix added");
    repeat (3) begin
      cyc(0, 0, 0, 0, 32'h3008);
      chk_all("R8 idle hold");
    end
    // R10: empty status still requests because of old flags
    cyc(1, 13'h0000, 0, 0, 32'h300C);
    chk_all("R10 empty status old flags");
    // R9: write disabling enable, status still applied (old enable)
    cyc(1, 13'h0800, 1, 32'h0, 32'h3010);
    chk_all("R9 write disables, status kept");
    // R3/R11: disabled now, status ignored, pc holds
    cyc(1, 13'h0200, 0, 0, 32'h3014);
    chk_all("R3 ignored after disable");
    chk("R11 pc hold", exc_pc, 32'h3010);
    // R10: empty update with no flags raises nothing
    cyc(0, 0, 1, 32'h1, 0);
    cyc(1, 13'h0000, 0, 0, 32'h3018);
    chk_all("R10 no flags no req");
    // R10: back-to-back updates give back-to-back pulses, then drop
    cyc(1, 13'h0001, 0, 0, 32'h4000);
    chk_all("R10 pulse a");
    cyc(1, 13'h0004, 0, 0, 32'h4004);
    chk_all("R10 pulse b");
    cyc(0, 0, 0, 0, 32'h4008);
    chk_all("R10 pulse ends");

    // R1: reset mid-run clears everything
    rst_n = 0;
    @(negedge clk);
    m_reg = '0; m_pc = '0; m_req = 0;
    chk_all("R1 mid reset");
    rst_n = 1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule